// File: doc/BRIEF.md
# Threshold-Gate Grouped Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in. Its carry network is built from modelled threshold gates. Each gate forms an integer-weighted sum of its inputs and fires when that sum reaches a fixed threshold. The operand bits are cut into groups of `GRP` adjacent positions. Each group produces a generate flag and a propagate flag directly from one weighted comparison of its operand bits, so the datapath contains no per-bit generate or propagate terms. Within a group, operand bit i carries weight 2^i.

The group flags pass through a logarithmic-depth parallel-prefix network, which uses the operator (G, P) = (Gh | (Ph & Gl), Ph & Pl). The carry-in is merged into the lowest group before that network. Each group then forms the carries into its own bit positions from its incoming carry, again with threshold gates, and produces its sum bits by parity. When `WIDTH` is not a multiple of `GRP`, the most significant group is narrower than the others.

The sum and carry-out are registered once, so the result appears one clock edge after the operands. An asynchronous active-low reset clears the result.

Top module: `tl_cla_adder`

## Requirements
- R1: One rising clock edge after the operands and carry-in are applied, {cout_o, sum_o} equals a_i + b_i + cin_i as an unsigned value of WIDTH+1 bits.
- R2: While rst_ni is low, sum_o and cout_o are 0, whatever the inputs are.
- R3: When the operand bits of the most significant group add up to more than 2^w − 1 (w is that group's width), cout_o is 1 whatever the lower bits and cin_i are. Example: at WIDTH=16, a_i = b_i = 16'h8000 gives cout_o = 1 and sum_o = 0.
- R4: When every group's operand bits add up to exactly 2^w − 1 (b_i = ~a_i), the carry-in travels the whole width. With cin_i = 0 the result is sum_o = all ones and cout_o = 0. With cin_i = 1 it is sum_o = 0 and cout_o = 1.
- R5: The carry-in enters at bit 0 through the lowest group. With a_i = b_i = 0 and cin_i = 1, sum_o is 1 and cout_o is 0.
- R6: A carry leaving one full group reaches the next group. Example: at WIDTH=16, GRP=3, 16'h0007 + 16'h0001 gives 16'h0008, and 16'h01FF + 16'h0001 gives 16'h0200.
- R7: Widths that are not a multiple of GRP add correctly with a narrower top group. This covers WIDTH=16, GRP=3 (top group 1 bit) and WIDTH=4, GRP=3 (groups of 3 and 1 bits), which must be correct for all 512 input combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the result is registered on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the result register |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry out of the top bit |

## Verification
The bench targets the full propagate chain b = ~a with both carry-in values. A prefix network with a wrong span or a wrongly folded carry-in gives a wrong carry-out or a partly inverted sum on this case. It also drives carries across group edges, for example 0x01FF + 1. A design that compares group sums with the wrong threshold (for example ≥ 2^n for propagate) drops these carries and leaves zeros in the wrong positions. The narrow top group is covered by the 16-bit default and by an exhaustive sweep of a 4-bit instance with groups of 3 and 1 bits, where a bad slice offset or gate width corrupts the top sum bit or cout_o. The bench also checks that no result appears before the register edge and that reset clears the outputs while the inputs are active.

// File: rtl/tlcla_pkg.sv
package tlcla_pkg;

    // Number of groups needed to cover a width with groups of n bits.
    function automatic int grp_count(input int width, input int n);
        return (width + n - 1) / n;
    endfunction

    // Width of group k; only the top group may be narrower.
    function automatic int grp_width(input int width, input int n, input int k);
        int ng;
        ng = grp_count(width, n);
        if (k == ng - 1) return width - (ng - 1) * n;
        return n;
    endfunction

endpackage

// File: rtl/tl_thresh_gate.sv
// Modelled threshold gate: x and y bit i weigh 2^i, bias weighs 1.
// Fires when the weighted sum is at least THRESH.
module tl_thresh_gate #(
    parameter int BITS   = 3,
    parameter int THRESH = 8
) (
    input  logic [BITS-1:0] x_i,
    input  logic [BITS-1:0] y_i,
    input  logic            bias_i,
    output logic            fire_o
);
    localparam int SW = BITS + 1;

    logic [SW-1:0] wsum;

    assign wsum   = {1'b0, x_i} + {1'b0, y_i} + SW'(bias_i);
    assign fire_o = (wsum >= SW'(THRESH));
endmodule

// File: rtl/tl_group.sv
// One operand group: generate/propagate from a single weighted comparison
// each, and internal carries derived from the group's incoming carry.
module tl_group #(
    parameter int GW = 3
) (
    input  logic [GW-1:0] a_i,
    input  logic [GW-1:0] b_i,
    input  logic          cin_i,
    output logic          gen_o,
    output logic          prop_o,
    output logic [GW-1:0] sum_o
);
    localparam int MAXV = (1 << GW) - 1;

    logic [GW-1:0] cbit;

    // Generate: group sum strictly above the largest GW-bit value.
    tl_thresh_gate #(.BITS(GW), .THRESH(MAXV + 1)) u_gen (
        .x_i(a_i), .y_i(b_i), .bias_i(1'b0), .fire_o(gen_o)
    );

    // Propagate: group sum at least the largest GW-bit value.
    tl_thresh_gate #(.BITS(GW), .THRESH(MAXV)) u_prop (
        .x_i(a_i), .y_i(b_i), .bias_i(1'b0), .fire_o(prop_o)
    );

    assign cbit[0] = cin_i;

    // Carry into position j: low j bits plus incoming carry reach 2^j.
    for (genvar j = 1; j < GW; j++) begin : g_cin
        tl_thresh_gate #(.BITS(j), .THRESH(1 << j)) u_c (
            .x_i   (a_i[j-1:0]),
            .y_i   (b_i[j-1:0]),
            .bias_i(cin_i),
            .fire_o(cbit[j])
        );
    end

    assign sum_o = a_i ^ b_i ^ cbit;
endmodule

// File: rtl/tl_prefix.sv
// Logarithmic-depth parallel-prefix network over group (G,P) pairs.
// carry_o[0] is the carry-in, carry_o[k+1] the carry out of group k.
module tl_prefix #(
    parameter int NG = 6
) (
    input  logic [NG-1:0] g_i,
    input  logic [NG-1:0] p_i,
    input  logic          cin_i,
    output logic [NG:0]   carry_o
);
    localparam int LVL = (NG > 1) ? $clog2(NG) : 0;

    logic [NG-1:0] gv_d;
    logic [NG-1:0] pv_d;

    always_comb begin
        gv_d    = g_i;
        pv_d    = p_i;
        // Fold carry-in into the lowest group.
        gv_d[0] = g_i[0] | (p_i[0] & cin_i);
        pv_d[0] = 1'b0;
        for (int l = 0; l < LVL; l++) begin
            // (G,P) = (Gh | Ph&Gl, Ph&Pl) with span 2^l.
            gv_d = gv_d | (pv_d & (gv_d << (1 << l)));
            pv_d = pv_d & ((pv_d << (1 << l)) | ~({NG{1'b1}} << (1 << l)));
        end
        carry_o = {gv_d, cin_i};
    end
endmodule

// File: rtl/tl_cla_adder.sv
module tl_cla_adder
    import tlcla_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int GRP   = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int NG = grp_count(WIDTH, GRP);
    localparam int OW = WIDTH + 1;

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
        logic             live;
    } res_t;

    logic [NG-1:0]    grp_g;
    logic [NG-1:0]    grp_p;
    logic [NG:0]      grp_c;
    logic [WIDTH-1:0] sum_w;
    res_t             res_d;
    res_t             res_q;

    for (genvar k = 0; k < NG; k++) begin : g_grp
        localparam int LO = k * GRP;
        localparam int GW = grp_width(WIDTH, GRP, k);
        tl_group #(.GW(GW)) u_grp (
            .a_i   (a_i[LO+GW-1:LO]),
            .b_i   (b_i[LO+GW-1:LO]),
            .cin_i (grp_c[k]),
            .gen_o (grp_g[k]),
            .prop_o(grp_p[k]),
            .sum_o (sum_w[LO+GW-1:LO])
        );
    end

    tl_prefix #(.NG(NG)) u_prefix (
        .g_i    (grp_g),
        .p_i    (grp_p),
        .cin_i  (cin_i),
        .carry_o(grp_c)
    );

    always_comb begin
        res_d      = res_q;
        res_d.sum  = sum_w;
        res_d.cout = grp_c[NG];
        res_d.live = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign sum_o  = res_q.sum;
    assign cout_o = res_q.cout;

    // R1
    sum_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_q.live |-> ({cout_o, sum_o} ==
            ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + OW'($past(cin_i)))));

    // R3
    gen_within_prop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(grp_g & ~grp_p) == 0);

    // R3
    top_gen_cout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grp_g[NG-1] |=> cout_o);

    // R4
    full_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (&grp_p && !(|grp_g)) |=> (cout_o == $past(cin_i)));

    // R5
    cin_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_i == '0 && b_i == '0) |=> (sum_o == WIDTH'($past(cin_i)) && !cout_o));
endmodule

// File: tb/sim_tl_cla_adder.sv
`timescale 1ns/1ps
module sim_tl_cla_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a16 = '0, b16 = '0;
    logic        c16 = 1'b0;
    logic [15:0] s16;
    logic        co16;
    logic [3:0]  a4 = '0, b4 = '0;
    logic        c4 = 1'b0;
    logic [3:0]  s4;
    logic        co4;
    int          nchk = 0;
    int          nbad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    tl_cla_adder #(.WIDTH(16), .GRP(3)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .a_i(a16), .b_i(b16), .cin_i(c16),
        .sum_o(s16), .cout_o(co16)
    );

    tl_cla_adder #(.WIDTH(4), .GRP(3)) u1 (
        .clk_i(clk), .rst_ni(rst_n), .a_i(a4), .b_i(b4), .cin_i(c4),
        .sum_o(s4), .cout_o(co4)
    );

    function automatic logic [16:0] ref16(input logic [15:0] a, input logic [15:0] b, input logic c);
        return {1'b0, a} + {1'b0, b} + 17'(c);
    endfunction

    function automatic logic [4:0] ref4(input logic [3:0] a, input logic [3:0] b, input logic c);
        return {1'b0, a} + {1'b0, b} + 5'(c);
    endfunction

    task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    endtask

    // Apply to both instances at a falling edge, check at the next falling edge.
    task automatic step(input logic [15:0] a, input logic [15:0] b, input logic c,
                        input logic [3:0] x, input logic [3:0] y, input logic z,
                        input string tag);
        @(negedge clk);
        a16 = a; b16 = b; c16 = c;
        a4  = x; b4  = y; c4  = z;
        @(negedge clk);
        chk({tag, " w16"}, {co16, s16}, ref16(a, b, c));
        chk({tag, " w4"}, 17'({co4, s4}), 17'(ref4(x, y, z)));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd7319);

        // R2: outputs cleared while reset is low, inputs active.
        a16 = 16'hFFFF; b16 = 16'h0001; c16 = 1'b1;
        a4  = 4'hF;     b4  = 4'h1;     c4  = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 reset w16", {co16, s16}, 17'h0);
        chk("R2 reset w4", 17'({co4, s4}), 17'h0);
        rst_n = 1'b1;

        // R1: result appears one edge after the inputs, not before.
        @(negedge clk);
        a16 = 16'h1234; b16 = 16'h4321; c16 = 1'b0;
        #1;
        chk("R1 no early result", {co16, s16}, ref16(16'hFFFF, 16'h0001, 1'b1));
        @(negedge clk);
        chk("R1 one edge latency", {co16, s16}, ref16(16'h1234, 16'h4321, 1'b0));

        // R5: carry-in enters at bit 0.
        step(16'h0000, 16'h0000, 1'b1, 4'h0, 4'h0, 1'b1, "R5 cin only");
        step(16'hFFFF, 16'h0000, 1'b1, 4'hF, 4'h0, 1'b1, "R5 cin ripple");

        // R4: full propagate chain, both carry-in values.
        step(16'hA5C3, 16'h5A3C, 1'b0, 4'h6, 4'h9, 1'b0, "R4 chain cin0");
        step(16'hA5C3, 16'h5A3C, 1'b1, 4'h6, 4'h9, 1'b1, "R4 chain cin1");
        step(16'h0000, 16'hFFFF, 1'b1, 4'h0, 4'hF, 1'b1, "R4 zero/ones cin1");

        // R3: top-group generate drives carry-out.
        step(16'h8000, 16'h8000, 1'b0, 4'h8, 4'h8, 1'b0, "R3 top gen");
        step(16'hFFFF, 16'hFFFF, 1'b1, 4'hF, 4'hF, 1'b1, "R3 all ones");

        // R6: carries cross group boundaries.
        step(16'h0007, 16'h0001, 1'b0, 4'h7, 4'h1, 1'b0, "R6 group edge");
        step(16'h01FF, 16'h0001, 1'b0, 4'h3, 4'h5, 1'b0, "R6 two groups");
        step(16'h7FFF, 16'h0000, 1'b1, 4'h7, 4'h0, 1'b1, "R6 into top group");

        // R7: exhaustive 4-bit instance, random 16-bit alongside.
        for (int i = 0; i < 512; i++) begin
            step(16'($urandom), 16'($urandom), 1'($urandom),
                 4'(i), 4'(i >> 4), 1'(i >> 8), "R7 exhaustive");
        end

        // R1: randomised 16-bit vectors, some forced to near-chains.
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            ra = 16'($urandom);
            rb = (i % 4 == 0) ? ~ra ^ (16'h1 << ($urandom % 16)) : 16'($urandom);
            step(ra, rb, 1'($urandom), 4'($urandom), 4'($urandom), 1'($urandom), "R1 random");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule